// File: doc/BRIEF.md
# Cyclic overwriting receive FIFO controller

This block keeps the bookkeeping for a receive FIFO that lives in a contiguous run of slots inside a larger message memory. The run starts at a programmable first slot index and ends at a programmable last slot index, so it can hold up to 128 slots. The block owns a write pointer and a read pointer, and the host cannot reach either of them. On each store or read request it returns the absolute slot index to use. It also keeps a fill level and three flags: not-empty, critical level and overrun.

The FIFO never drops incoming data. When it is full, a store overwrites the oldest entry and moves both pointers on. A read is granted only while at least one unread entry is held. The read pointer moves on only for a granted read, which is when a slot has been moved out to the output buffer. The slot memory, the frame contents and the filter decision all sit outside this block. A store arrives as a strobe and leaves as an address.

The block accepts one store and one read per cycle. Asserting `cfg_load_i` for one cycle rebuilds the FIFO after the range has been changed.

Top module: `rx_ring_ctrl`

## Requirements
- R1: After reset, and in the cycle after `cfg_load_i` is high, both pointers sit at `cfg_first_i`, `level_o` is 0 and all flags are 0. Requests made in the load cycle are ignored.
- R2: While `store_i` is high, `store_we_o` is high and `store_idx_o` gives the current write slot. After the edge, the write slot is the next one up.
- R3: A pointer that advances while it sits on `cfg_last_i` reloads `cfg_first_i`. This holds for both the write pointer and the read pointer.
- R4: `rd_valid_o` equals `rd_req_i` while `level_o` is nonzero and is 0 otherwise. `rd_idx_o` gives the current read slot. The read pointer advances only on a granted read or on an overrun.
- R5: A store while `level_o` equals the depth (last−first+1), with no granted read in the same cycle, advances both pointers and leaves `level_o` unchanged. It also sets the sticky `ovr_o` flag.
- R6: `ne_o` is high in every cycle in which `level_o` is nonzero.
- R7: `crit_o` is high in every cycle after the first clock edge following reset in which `level_o` ≥ `crit_lvl_i`, provided `crit_lvl_i` was stable over the last cycle.
- R8: A store and a granted read in the same cycle leave `level_o` unchanged. A store alone that does not overrun adds 1 to `level_o`. A granted read alone subtracts 1.
- R9: Writing 1 to a bit of `flag_clr_i` clears the matching flag. The bits are: bit 0 `ne_o`, bit 1 `crit_o`, bit 2 `ovr_o`. If the flag's set condition is true in the same cycle, the set wins.
- R10: `irq_o[k]` is the flag numbered k in R9, ANDed with `irq_en_i[k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_first_i | input | 8 | First slot index of the FIFO |
| cfg_last_i | input | 8 | Last slot index of the FIFO (must be ≥ first) |
| cfg_load_i | input | 1 | Reinitialise pointers, level and flags |
| crit_lvl_i | input | 8 | Critical fill-level threshold |
| irq_en_i | input | 3 | Interrupt enables (bit 0 ne, bit 1 crit, bit 2 ovr) |
| flag_clr_i | input | 3 | Write-one-to-clear for the flags |
| store_i | input | 1 | Store request |
| rd_req_i | input | 1 | Read request |
| store_we_o | output | 1 | Slot write strobe |
| store_idx_o | output | 8 | Absolute slot index for the store |
| rd_valid_o | output | 1 | Read granted |
| rd_idx_o | output | 8 | Absolute slot index for the read |
| level_o | output | 8 | Fill level |
| ne_o | output | 1 | Not-empty flag |
| crit_o | output | 1 | Critical-level flag |
| ovr_o | output | 1 | Sticky overrun flag |
| irq_o | output | 3 | Gated interrupts |

## Verification
The slot indices, `store_we_o`, `rd_valid_o` and `irq_o` are combinational from the current state and inputs. The bench checks them 1 ns after it drives the inputs, in the same cycle. The pointers, `level_o` and the three flags register at the following rising edge. They are checked 1 ns after that edge, against a bench model updated by the same rule. The bench sweeps several base indices, every depth from 1 to 5, and the full 128-slot case, with a pseudo-random mix of stores, reads and clears that reaches full, empty, overrun and wrap.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int unsigned FLG_NE   = 0;
  localparam int unsigned FLG_CRIT = 1;
  localparam int unsigned FLG_OVR  = 2;
  localparam int unsigned NUM_FLG  = 3;
  localparam int unsigned NUM_PTR  = 2;
  localparam int unsigned PTR_WR   = 0;
  localparam int unsigned PTR_RD   = 1;
endpackage

// File: rtl/ring_ptr.sv
module ring_ptr #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] first_i,
  input  logic [IDX_W-1:0] span_i,
  input  logic             load_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o
);
  // pointer held as offset from first slot: reset value lands on first
  logic [IDX_W-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      off_q <= '0;
    else if (load_i)  off_q <= '0;
    else if (adv_i)   off_q <= (off_q == span_i) ? '0 : off_q + 1'b1;
  end

  assign idx_o = first_i + off_q;

  assert_ptr_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && off_q == span_i) |=> (off_q == '0));
  assert_ptr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && off_q != span_i) |=> (off_q == $past(off_q) + 1'b1));
endmodule

// File: rtl/ring_level.sv
module ring_level #(
  parameter int unsigned LVL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LVL_W-1:0] depth_i,
  input  logic             store_i,
  input  logic             rd_req_i,
  output logic             rd_fire_o,
  output logic             ovr_ev_o,
  output logic [LVL_W-1:0] level_o,
  output logic [LVL_W-1:0] level_nxt_o
);
  logic [LVL_W-1:0] lvl_q;
  logic             full, empty, st, rd;

  assign empty     = (lvl_q == '0);
  assign full      = (lvl_q == depth_i);
  assign st        = store_i  && !load_i;
  assign rd        = rd_req_i && !load_i && !empty;
  assign rd_fire_o = rd;
  assign ovr_ev_o  = st && full && !rd;

  always_comb begin
    level_nxt_o = lvl_q;
    if (load_i)               level_nxt_o = '0;
    else if (st && !rd && !full) level_nxt_o = lvl_q + 1'b1;
    else if (rd && !st)       level_nxt_o = lvl_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= level_nxt_o;
  end

  assign level_o = lvl_q;

  assert_ovr_level_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_ev_o |=> (lvl_q == $past(lvl_q)));
  assert_same_cycle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st && rd) |=> $stable(lvl_q));
  assert_load_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (lvl_q == '0));
endmodule

// File: rtl/ring_flags.sv
module ring_flags
  import rx_ring_pkg::*;
#(
  parameter int unsigned LVL_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [LVL_W-1:0]   level_i,
  input  logic [LVL_W-1:0]   level_nxt_i,
  input  logic [LVL_W-1:0]   crit_lvl_i,
  input  logic               ovr_ev_i,
  input  logic [NUM_FLG-1:0] clr_i,
  input  logic [NUM_FLG-1:0] en_i,
  output logic [NUM_FLG-1:0] flag_o,
  output logic [NUM_FLG-1:0] irq_o
);
  logic [NUM_FLG-1:0] flg_q, set;
  logic               armed_q;

  assign set[FLG_NE]   = (level_nxt_i != '0);
  assign set[FLG_CRIT] = (level_nxt_i >= crit_lvl_i);
  assign set[FLG_OVR]  = ovr_ev_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flg_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (load_i) flg_q <= '0;
      else        flg_q <= set | (flg_q & ~clr_i);
    end
  end

  assign flag_o = flg_q;
  assign irq_o  = flg_q & en_i;

  assert_ne_tracks_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i != '0) |-> flg_q[FLG_NE]);
  assert_crit_tracks_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !$past(load_i) && $stable(crit_lvl_i) && level_i >= crit_lvl_i) |-> flg_q[FLG_CRIT]);
  assert_ovr_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_ev_i && !load_i) |=> flg_q[FLG_OVR]);
  assert_ovr_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flg_q[FLG_OVR] && !clr_i[FLG_OVR] && !load_i) |=> flg_q[FLG_OVR]);
endmodule

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_ring_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned LVL_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IDX_W-1:0]   cfg_first_i,
  input  logic [IDX_W-1:0]   cfg_last_i,
  input  logic               cfg_load_i,
  input  logic [LVL_W-1:0]   crit_lvl_i,
  input  logic [NUM_FLG-1:0] irq_en_i,
  input  logic [NUM_FLG-1:0] flag_clr_i,
  input  logic               store_i,
  input  logic               rd_req_i,
  output logic               store_we_o,
  output logic [IDX_W-1:0]   store_idx_o,
  output logic               rd_valid_o,
  output logic [IDX_W-1:0]   rd_idx_o,
  output logic [LVL_W-1:0]   level_o,
  output logic               ne_o,
  output logic               crit_o,
  output logic               ovr_o,
  output logic [NUM_FLG-1:0] irq_o
);
  localparam int unsigned DW = (IDX_W > LVL_W) ? IDX_W : LVL_W;

  logic [IDX_W-1:0]   span;
  logic [DW-1:0]      depth_wide;
  logic [LVL_W-1:0]   depth, lvl_nxt;
  logic               rd_fire, ovr_ev;
  logic [NUM_PTR-1:0] adv;
  logic [IDX_W-1:0]   idx [NUM_PTR];
  logic [NUM_FLG-1:0] flags;

  assign span       = cfg_last_i - cfg_first_i;
  assign depth_wide = DW'(span) + 1'b1;
  assign depth      = depth_wide[LVL_W-1:0];

  ring_level #(.LVL_W(LVL_W)) u_level (
    .clk_i, .rst_ni,
    .load_i      (cfg_load_i),
    .depth_i     (depth),
    .store_i     (store_i),
    .rd_req_i    (rd_req_i),
    .rd_fire_o   (rd_fire),
    .ovr_ev_o    (ovr_ev),
    .level_o     (level_o),
    .level_nxt_o (lvl_nxt)
  );

  assign adv[PTR_WR] = store_i && !cfg_load_i;
  assign adv[PTR_RD] = rd_fire || ovr_ev;

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    ring_ptr #(.IDX_W(IDX_W)) u_ptr (
      .clk_i, .rst_ni,
      .first_i (cfg_first_i),
      .span_i  (span),
      .load_i  (cfg_load_i),
      .adv_i   (adv[g]),
      .idx_o   (idx[g])
    );
  end

  ring_flags #(.LVL_W(LVL_W)) u_flags (
    .clk_i, .rst_ni,
    .load_i      (cfg_load_i),
    .level_i     (level_o),
    .level_nxt_i (lvl_nxt),
    .crit_lvl_i  (crit_lvl_i),
    .ovr_ev_i    (ovr_ev),
    .clr_i       (flag_clr_i),
    .en_i        (irq_en_i),
    .flag_o      (flags),
    .irq_o       (irq_o)
  );

  assign store_we_o  = adv[PTR_WR];
  assign store_idx_o = idx[PTR_WR];
  assign rd_valid_o  = rd_fire;
  assign rd_idx_o    = idx[PTR_RD];
  assign ne_o        = flags[FLG_NE];
  assign crit_o      = flags[FLG_CRIT];
  assign ovr_o       = flags[FLG_OVR];

  assert_no_read_empty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> ne_o);
  assert_ovr_both_move_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_ev && $stable(cfg_first_i) && $stable(cfg_last_i)) |=> (store_idx_o == rd_idx_o));
endmodule

// File: tb/rx_ring_ctrl_tb_top.sv
module rx_ring_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] first = '0, last = '0, thr = '0;
  logic       load = 1'b0, st = 1'b0, rd = 1'b0;
  logic [2:0] en = '0, clr = '0;
  logic       we, rv, ne, crit, ovr;
  logic [7:0] sidx, ridx, lvl;
  logic [2:0] irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // model
  int m_wr, m_rd, m_lvl, m_depth;
  bit m_ne, m_crit, m_ovr;

  always #2 clk = ~clk;

  rx_ring_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_first_i(first), .cfg_last_i(last),
    .cfg_load_i(load), .crit_lvl_i(thr), .irq_en_i(en), .flag_clr_i(clr),
    .store_i(st), .rd_req_i(rd), .store_we_o(we), .store_idx_o(sidx),
    .rd_valid_o(rv), .rd_idx_o(ridx), .level_o(lvl), .ne_o(ne),
    .crit_o(crit), .ovr_o(ovr), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nxt(input int p);
    return (p == int'(last)) ? int'(first) : p + 1;
  endfunction

  task automatic check_state();
    chk("R8 level", lvl, m_lvl);
    chk("R2 write slot", sidx, m_wr);
    chk("R4 read slot", ridx, m_rd);
    chk("R6 ne", ne, m_ne);
    chk("R7 crit", crit, m_crit);
    chk("R5 ovr", ovr, m_ovr);
    chk("R10 irq", irq, {m_ovr, m_crit, m_ne} & en);
  endtask

  task automatic step(input bit s, input bit r, input bit[2:0] c, input bit ld);
    bit fire, ev;
    int ln;
    @(negedge clk);
    st = s; rd = r; clr = c; load = ld;
    #1;
    fire = r && !ld && m_lvl != 0;
    ev   = s && !ld && m_lvl == m_depth && !fire;
    chk("R2 we", we, s && !ld);
    chk("R4 rd_valid", rv, fire);
    if (s && !ld) chk("R2 store idx", sidx, m_wr);
    if (fire)     chk("R4 rd idx", ridx, m_rd);
    @(posedge clk);
    #1;
    if (ld) begin
      m_wr = first; m_rd = first; m_lvl = 0;
      m_ne = 0; m_crit = 0; m_ovr = 0;
    end else begin
      ln = m_lvl;
      if (s && !fire && m_lvl != m_depth) ln = m_lvl + 1;
      else if (fire && !s) ln = m_lvl - 1;
      if (s) m_wr = nxt(m_wr);
      if (fire || ev) m_rd = nxt(m_rd);
      m_lvl  = ln;
      m_ne   = (ln != 0) || (m_ne && !c[0]);
      m_crit = (ln >= int'(thr)) || (m_crit && !c[1]);
      m_ovr  = ev || (m_ovr && !c[2]);
    end
    check_state();
  endtask

  task automatic configure(input int f, input int d, input int t);
    @(negedge clk);
    first = 8'(f); last = 8'(f + d - 1); thr = 8'(t);
    m_depth = d;
    step(1'b1, 1'b1, 3'b000, 1'b1);  // R1 load with requests present
    chk("R1 load level", lvl, 0);
    chk("R1 load ptr", sidx, f);
    chk("R1 load rd ptr", ridx, f);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] lf;
    int bases [3] = '{0, 7, 250};
    lf = 16'hACE1;
    m_depth = 1; m_wr = 0; m_rd = 0; m_lvl = 0;
    m_ne = 0; m_crit = 0; m_ovr = 0;
    first = 8'd0; last = 8'd0; thr = 8'd0;
    #7;
    chk("R1 reset level", lvl, 0);
    chk("R1 reset ovr", ovr, 0);
    chk("R1 reset ne", ne, 0);
    rst_n = 1'b1;
    // sweep base x depth
    foreach (bases[b]) begin
      for (int d = 1; d <= 5; d++) begin
        if (bases[b] + d - 1 > 255) continue;
        configure(bases[b], d, (d + 1) / 2);
        en = 3'(d);
        // fill past full to hit overrun and wrap (R3, R5)
        for (int i = 0; i < d + 2; i++) step(1'b1, 1'b0, 3'b000, 1'b0);
        chk("R5 ovr after overfill", ovr, 1);
        step(1'b0, 1'b0, 3'b100, 1'b0);  // R9 clear overrun
        chk("R9 ovr cleared", ovr, 0);
        for (int i = 0; i < 60; i++) begin
          lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
          step(lf[0] | lf[5], lf[1] | lf[7], (lf[3:2] == 2'b11) ? lf[10:8] : 3'b000, 1'b0);
        end
        // drain past empty (R4)
        for (int i = 0; i < d + 2; i++) step(1'b0, 1'b1, 3'b000, 1'b0);
        chk("R4 drained", lvl, 0);
        step(1'b0, 1'b0, 3'b011, 1'b0);
        chk("R9 ne cleared when empty", ne, 0);
      end
    end
    // full 128-slot case, threshold 0
    configure(0, 128, 0);
    en = 3'b111;
    for (int i = 0; i < 130; i++) step(1'b1, 1'b0, 3'b000, 1'b0);
    chk("R5 level capped", lvl, 128);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 3'b000, 1'b0);  // R8
    for (int i = 0; i < 129; i++) step(1'b0, 1'b1, 3'b010, 1'b0);
    chk("R7 crit threshold zero", crit, 1);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule